// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the serial slave interface of a page-organised flash device. The host frames each operation with an active-low chip select. While selected, the host clocks in an 8-bit opcode and a 24-bit address on the serial input, most significant bit first. For program commands it then sends write data bytes. The block classifies every opcode through a parameterised lookup and splits the address into a page number and a byte offset. It then hands a one-cycle request to a backend that models the storage array.

Read data from the backend is shifted out on the serial output. A status opcode returns a ready bit. A write-protect pin blocks program and erase commands and permanently freezes the protect-register write until power-on reset. The protection-enable and lockdown commands still pass while the pin is low. A separate hardware reset input aborts whatever is running. Once a program or erase frame is closed, the block holds busy until the backend reports completion.

The SPI pins are sampled by the system clock and must be slow enough that every SCK level lasts at least two clock cycles. The output enable is meant to drive a pad tri-state.

Top module: `spi_flash_fe`

## Requirements
- R1: A frame opens only on a high-to-low transition of cs_ni while hw_rst_ni is high, and closes on its low-to-high transition. SCK edges outside an open frame shift nothing.
- R2: SI is captured on SCK rising edges and so_o changes only on SCK falling edges. Each frame is an opcode byte and then three address bytes, all MSB first. Default opcodes are: read 0x03; program 0x02; page erase 0x81; block erase 0x50; protection enable 0x3D; lockdown 0x7F; protect-register write 0xFC; status 0xD7.
- R3: so_oe_o is 1 only inside an open frame, so the output floats whenever chip select is high.
- R4: A program or erase opcode with wp_ni low at its opcode or last address byte issues no request and sets no busy. The next frame is decoded normally.
- R5: Protection-enable and lockdown opcodes issue their request regardless of wp_ni.
- R6: Once wp_ni has been sampled low after rst_ni, every protect-register write frame is dropped.
- R7: While hw_rst_ni is low, the open frame is aborted, busy clears, no frame can open and no request is issued.
- R8: Closing a frame whose program or erase request was issued sets busy_o. busy_o then holds until be_done_i is asserted.
- R9: While busy_o is 1, every opcode except status is ignored. A status frame returns bytes whose bit 7 is the inverse of busy and whose other bits are 0.
- R10: A frame that closes before its third address byte is complete issues no request.
- R11: req_class_o encodes 0 for read, 1 for program/erase, 2 for protection and 3 for any other opcode. The page number and byte offset come from the low address bits: with 528-byte pages the offset is address bits 9:0 and the page is bits 21:10. With BIN_PAGES=1 these are bits 8:0 and 20:9.
- R12: On a read, the backend byte is loaded when the last address bit arrives and another after every following byte, each load pulsing rd_pop_o. On a non-read accepted frame, every whole data byte pulses wr_valid_o with wr_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| hw_rst_ni | input | 1 | Hardware reset pin, active low, sampled |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Write protect, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| req_valid_o | output | 1 | One-cycle command request |
| req_op_o | output | 8 | Opcode of the request |
| req_class_o | output | 2 | Opcode class |
| req_page_o | output | PAGE_W | Page number |
| req_offs_o | output | OFFS_W | Byte offset within page |
| wr_valid_o | output | 1 | Write data byte strobe |
| wr_data_o | output | 8 | Write data byte |
| rd_data_i | input | 8 | Next read byte from the backend |
| rd_pop_o | output | 1 | Read byte consumed |
| busy_o | output | 1 | Self-timed operation in progress |
| be_done_i | input | 1 | Backend completion pulse |

## Verification
Every cycle, the checker tests that the output floats outside a frame and that no program request leaves while write-protect is low. It also tests that no protect-register write appears after the pin has ever dropped, that hardware reset leaves the block idle, and that busy holds until completion with no request while busy. Only the bench scenarios can show that SI bits land in the right order and that bytes shifted out match the backend sequence. The same holds for the page and offset split, the status byte contents, and the silent discard of short or deselected traffic.

// File: rtl/spi_flash_fe_pkg.sv
package spi_flash_fe_pkg;
  typedef enum logic [1:0] {
    CLS_READ  = 2'd0,
    CLS_PROG  = 2'd1,
    CLS_PROT  = 2'd2,
    CLS_OTHER = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_ADDR, FS_DATA, FS_READ, FS_STAT, FS_DROP
  } fstate_e;

  localparam int unsigned ADDR_BYTES = 3;
  localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/spi_fe_edge.sv
module spi_fe_edge #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  nbytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; cnt_q <= '0; nbytes_q <= '0;
      byte_o <= '0; vld_o <= 1'b0; idx_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (clr_i) begin
        sr_q <= '0; cnt_q <= '0; nbytes_q <= '0;
      end else if (shift_i) begin
        sr_q <= {sr_q[BYTE_W-2:0], bit_i};
        if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          byte_o <= {sr_q[BYTE_W-2:0], bit_i};
          vld_o  <= 1'b1;
          idx_o  <= nbytes_q;
          if (nbytes_q != IDX_MAX) nbytes_q <= nbytes_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              fall_i,
  output logic              so_o
);
  logic [BYTE_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; so_o <= 1'b0;
    end else if (clr_i) begin
      sr_q <= '0; so_o <= 1'b0;
    end else if (load_i) begin
      sr_q <= data_i;
    end else if (fall_i) begin
      so_o <= sr_q[BYTE_W-1];
      sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_flash_fe.sv
module spi_flash_fe
  import spi_flash_fe_pkg::*;
#(
  parameter int         PAGE_W       = 12,
  parameter bit         BIN_PAGES    = 1'b0,
  parameter logic [7:0] OP_READ      = 8'h03,
  parameter logic [7:0] OP_PROG      = 8'h02,
  parameter logic [7:0] OP_ERASE_PG  = 8'h81,
  parameter logic [7:0] OP_ERASE_BLK = 8'h50,
  parameter logic [7:0] OP_PROT_EN   = 8'h3D,
  parameter logic [7:0] OP_LOCK      = 8'h7F,
  parameter logic [7:0] OP_PROT_WR   = 8'hFC,
  parameter logic [7:0] OP_STATUS    = 8'hD7,
  localparam int        OFFS_W       = BIN_PAGES ? 9 : 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              wp_ni,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              req_valid_o,
  output logic [7:0]        req_op_o,
  output logic [1:0]        req_class_o,
  output logic [PAGE_W-1:0] req_page_o,
  output logic [OFFS_W-1:0] req_offs_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_data_o,
  input  logic [7:0]        rd_data_i,
  output logic              rd_pop_o,
  output logic              busy_o,
  input  logic              be_done_i
);
  localparam int USE_W = PAGE_W + OFFS_W;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES);

  logic cs_rise, cs_fall, sck_rise, sck_fall;
  logic in_frame_q, busy_q, wp_frozen_q;
  fstate_e   state_q;
  op_class_e cls_q, cls_lu;
  logic [7:0] op_q;
  logic [USE_W-9:0] addr_q;
  logic [USE_W-1:0] addr_full;
  logic [7:0] rx_byte;
  logic rx_vld;
  logic [IDX_W-1:0] rx_idx;
  logic frame_start, step, addr_last, issue, take_rd, take_st, tx_load;
  logic wp_block_op, wp_block_q;
  logic [7:0] tx_data;

  spi_fe_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk_i, .rst_ni, .sig_i(cs_ni), .rise_o(cs_rise), .fall_o(cs_fall));
  spi_fe_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk_i, .rst_ni, .sig_i(sck_i), .rise_o(sck_rise), .fall_o(sck_fall));

  assign frame_start = cs_fall & hw_rst_ni;

  spi_fe_rx #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_rx (
    .clk_i, .rst_ni,
    .clr_i  (frame_start | ~hw_rst_ni),
    .shift_i(sck_rise & in_frame_q),
    .bit_i  (si_i),
    .byte_o (rx_byte),
    .vld_o  (rx_vld),
    .idx_o  (rx_idx));

  always_comb begin
    if (rx_byte == OP_READ) cls_lu = CLS_READ;
    else if (rx_byte == OP_PROG || rx_byte == OP_ERASE_PG || rx_byte == OP_ERASE_BLK)
      cls_lu = CLS_PROG;
    else if (rx_byte == OP_PROT_EN || rx_byte == OP_LOCK || rx_byte == OP_PROT_WR)
      cls_lu = CLS_PROT;
    else cls_lu = CLS_OTHER;
  end

  // protect-register write is frozen by the sticky flag or a low pin right now
  assign wp_block_op = (cls_lu == CLS_PROG && !wp_ni) ||
                       (rx_byte == OP_PROT_WR && (wp_frozen_q || !wp_ni));
  assign wp_block_q  = (cls_q == CLS_PROG && !wp_ni) ||
                       (op_q == OP_PROT_WR && (wp_frozen_q || !wp_ni));

  assign addr_full = {addr_q, rx_byte};
  assign step      = rx_vld & in_frame_q;
  assign addr_last = rx_idx == IDX_LAST;
  assign issue     = step && state_q == FS_ADDR && addr_last && !wp_block_q;
  assign take_rd   = (issue && cls_q == CLS_READ) || (step && state_q == FS_READ);
  assign take_st   = step && ((state_q == FS_IDLE && rx_byte == OP_STATUS) ||
                              state_q == FS_STAT);
  assign tx_load   = take_rd | take_st;
  assign tx_data   = take_rd ? rd_data_i : {~busy_q, 7'b0};

  spi_fe_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i, .rst_ni,
    .clr_i (frame_start),
    .load_i(tx_load),
    .data_i(tx_data),
    .fall_i(sck_fall & in_frame_q),
    .so_o  (so_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_frozen_q <= 1'b0;
    else if (!wp_ni) wp_frozen_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0; busy_q <= 1'b0; state_q <= FS_IDLE;
      cls_q <= CLS_OTHER; op_q <= '0; addr_q <= '0;
      req_valid_o <= 1'b0; req_op_o <= '0; req_class_o <= '0;
      req_page_o <= '0; req_offs_o <= '0;
      wr_valid_o <= 1'b0; wr_data_o <= '0; rd_pop_o <= 1'b0;
    end else if (!hw_rst_ni) begin
      in_frame_q <= 1'b0; busy_q <= 1'b0; state_q <= FS_IDLE;
      req_valid_o <= 1'b0; wr_valid_o <= 1'b0; rd_pop_o <= 1'b0;
    end else begin
      req_valid_o <= issue;
      wr_valid_o  <= 1'b0;
      rd_pop_o    <= take_rd;
      if (be_done_i) busy_q <= 1'b0;
      if (frame_start) begin
        in_frame_q <= 1'b1;
        state_q    <= FS_IDLE;
      end else if (cs_rise) begin
        in_frame_q <= 1'b0;
        state_q    <= FS_IDLE;
        if (state_q == FS_DATA && cls_q == CLS_PROG) busy_q <= 1'b1;
      end else if (step) begin
        unique case (state_q)
          FS_IDLE: begin
            op_q  <= rx_byte;
            cls_q <= cls_lu;
            if (rx_byte == OP_STATUS)         state_q <= FS_STAT;
            else if (busy_q || wp_block_op)   state_q <= FS_DROP;
            else                              state_q <= FS_ADDR;
          end
          FS_ADDR: begin
            addr_q <= addr_full[USE_W-9:0];
            if (addr_last) begin
              if (wp_block_q) state_q <= FS_DROP;
              else begin
                req_op_o    <= op_q;
                req_class_o <= cls_q;
                req_page_o  <= addr_full[OFFS_W +: PAGE_W];
                req_offs_o  <= addr_full[OFFS_W-1:0];
                state_q     <= (cls_q == CLS_READ) ? FS_READ : FS_DATA;
              end
            end
          end
          FS_DATA: begin
            wr_valid_o <= 1'b1;
            wr_data_o  <= rx_byte;
          end
          default: ;
        endcase
      end
    end
  end

  assign so_oe_o = in_frame_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/spi_flash_fe_chk.sv
module spi_flash_fe_chk #(
  parameter logic [7:0] OP_PROT_WR = 8'hFC
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hw_rst_ni,
  input logic       cs_ni,
  input logic       wp_ni,
  input logic       so_oe_o,
  input logic       req_valid_o,
  input logic [7:0] req_op_o,
  input logic [1:0] req_class_o,
  input logic       busy_o,
  input logic       be_done_i
);
  logic wp_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_seen_q <= 1'b0;
    else if (!wp_ni) wp_seen_q <= 1'b1;
  end

  AST_DESELECT_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) |-> !so_oe_o);                              // R3
  AST_WP_NO_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_class_o == 2'd1 |-> $past(wp_ni));             // R4
  AST_PROT_WR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_op_o == OP_PROT_WR |-> !wp_seen_q);            // R6
  AST_HWRST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_rst_ni |=> !busy_o && !so_oe_o && !req_valid_o);              // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !be_done_i && hw_rst_ni |=> busy_o);                    // R8
  AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_valid_o);                                         // R9
endmodule

bind spi_flash_fe spi_flash_fe_chk #(.OP_PROT_WR(OP_PROT_WR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_rst_ni(hw_rst_ni), .cs_ni(cs_ni),
  .wp_ni(wp_ni), .so_oe_o(so_oe_o), .req_valid_o(req_valid_o),
  .req_op_o(req_op_o), .req_class_o(req_class_o), .busy_o(busy_o),
  .be_done_i(be_done_i));

// File: tb/spi_flash_fe_bench.sv
module spi_flash_fe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, hw_rst_n = 1'b1, cs_n = 1'b1, sck = 1'b0;
  logic si = 1'b0, wp_n = 1'b1, be_done = 1'b0;
  logic so, so_oe, req_valid, wr_valid, rd_pop, busy;
  logic [7:0] req_op, wr_data;
  logic [1:0] req_class;
  logic [11:0] req_page;
  logic [9:0] req_offs;
  logic [7:0] rd_ctr = 8'h5A;

  int n_tests = 0, n_fail = 0;
  int req_cnt = 0, wr_cnt = 0;
  logic [7:0] rx_log [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_fe u_spi_flash_fe (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_ni(hw_rst_n), .cs_ni(cs_n),
    .sck_i(sck), .si_i(si), .wp_ni(wp_n), .so_o(so), .so_oe_o(so_oe),
    .req_valid_o(req_valid), .req_op_o(req_op), .req_class_o(req_class),
    .req_page_o(req_page), .req_offs_o(req_offs), .wr_valid_o(wr_valid),
    .wr_data_o(wr_data), .rd_data_i(rd_ctr), .rd_pop_o(rd_pop),
    .busy_o(busy), .be_done_i(be_done));

  always @(negedge clk) begin
    if (req_valid) req_cnt <= req_cnt + 1;
    if (wr_valid)  wr_cnt  <= wr_cnt + 1;
    if (rd_pop)    rd_ctr  <= rd_ctr + 8'd1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      tick(HALF);
      rx[i] = so;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic run_frame(input logic [7:0] op, input logic [23:0] addr,
                           input int n_addr, input int n_data, input logic [15:0] wdat);
    logic [7:0] tmp;
    cs_n = 1'b0; tick(2);
    xfer(op, tmp);
    for (int a = 0; a < n_addr; a++) xfer(addr[23-8*a -: 8], tmp);
    for (int d = 0; d < n_data; d++) begin
      xfer(wdat[15-8*d -: 8], tmp);
      rx_log[d] = tmp;
    end
    tick(2); cs_n = 1'b1; tick(3);
  endtask

  task automatic done_pulse();
    be_done = 1'b1; tick(1); be_done = 1'b0; tick(1);
  endtask

  // {opcode, wp_n, expect request, expect busy}
  localparam logic [10:0] VEC [8] = '{
    {8'h03, 1'b1, 1'b1, 1'b0},  // R12 read accepted
    {8'h02, 1'b1, 1'b1, 1'b1},  // R8 program sets busy
    {8'h81, 1'b0, 1'b0, 1'b0},  // R4 erase dropped under wp
    {8'h3D, 1'b0, 1'b1, 1'b0},  // R5 protection enable passes
    {8'h7F, 1'b0, 1'b1, 1'b0},  // R5 lockdown passes
    {8'hFC, 1'b1, 1'b0, 1'b0},  // R6 frozen after wp low
    {8'h50, 1'b1, 1'b1, 1'b1},  // R8 block erase
    {8'h9F, 1'b1, 1'b1, 1'b0}   // R11 other class
  };

  initial begin
    int r0, w0;
    logic [7:0] e0, tmp;
    tick(3); rst_n = 1'b1; tick(2);

    check("R3 reset oe", so_oe, 0);
    check("R8 reset busy", busy, 0);
    check("R7 reset req", req_cnt, 0);

    for (int v = 0; v < 8; v++) begin
      logic [7:0] op; logic wv, er, eb;
      {op, wv, er, eb} = VEC[v];
      wp_n = wv; tick(2);
      r0 = req_cnt;
      run_frame(op, 24'h012345, 3, 0, 16'h0);
      check($sformatf("R4/R5/R6 vec%0d req", v), req_cnt - r0, int'(er));
      check($sformatf("R8 vec%0d busy", v), busy, int'(eb));
      if (er && v == 7) check("R11 other class", req_class, 3);
      if (er && v == 3) check("R5 class prot", req_class, 2);
      if (eb) begin done_pulse(); check("R8 done clears", busy, 0); end
      wp_n = 1'b1;
    end

    // R2 R3 output enable follows frame
    cs_n = 1'b0; tick(3);
    check("R3 oe in frame", so_oe, 1);
    cs_n = 1'b1; tick(3);
    check("R3 oe after frame", so_oe, 0);

    // R11 page and offset split, R12 write strobes
    r0 = req_cnt; w0 = wr_cnt;
    run_frame(8'h02, 24'h2AF155, 3, 2, 16'hC33C);
    check("R11 page", req_page, 12'hABC);
    check("R11 offset", req_offs, 10'h155);
    check("R11 class prog", req_class, 1);
    check("R12 write count", wr_cnt - w0, 2);
    check("R12 write data", wr_data, 8'h3C);
    check("R8 busy after program", busy, 1);

    // R9 ignored while busy, status reports not ready
    r0 = req_cnt;
    run_frame(8'h03, 24'h000100, 3, 0, 16'h0);
    check("R9 read ignored while busy", req_cnt - r0, 0);
    run_frame(8'hD7, 24'h0, 0, 1, 16'h0);
    check("R9 status busy", rx_log[0], 8'h00);
    done_pulse();
    run_frame(8'hD7, 24'h0, 0, 1, 16'h0);
    check("R9 status ready", rx_log[0], 8'h80);

    // R12 R2 read data shifted out in order
    e0 = rd_ctr;
    run_frame(8'h03, 24'h000040, 3, 2, 16'h0);
    check("R12 read byte0", rx_log[0], e0);
    check("R12 read byte1", rx_log[1], e0 + 8'd1);
    check("R12 pops", rd_ctr - e0, 3);
    check("R11 class read", req_class, 0);

    // R10 short frame
    r0 = req_cnt;
    run_frame(8'h02, 24'h123456, 2, 0, 16'h0);
    check("R10 short frame req", req_cnt - r0, 0);
    check("R10 short frame busy", busy, 0);

    // R1 deselected clocks are ignored
    r0 = req_cnt;
    xfer(8'h03, tmp); xfer(8'h00, tmp);
    check("R1 deselected req", req_cnt - r0, 0);
    run_frame(8'h3D, 24'h000000, 3, 0, 16'h0);
    check("R1 frame op intact", req_op, 8'h3D);
    check("R1 frame req", req_cnt - r0, 1);

    // R7 hardware reset
    run_frame(8'h81, 24'h000200, 3, 0, 16'h0);
    check("R7 busy before reset", busy, 1);
    hw_rst_n = 1'b0; tick(2);
    check("R7 busy cleared", busy, 0);
    r0 = req_cnt;
    run_frame(8'h3D, 24'h0, 3, 0, 16'h0);
    check("R7 no request in reset", req_cnt - r0, 0);
    hw_rst_n = 1'b1; tick(2);
    run_frame(8'h3D, 24'h0, 3, 0, 16'h0);
    check("R7 resumes after reset", req_cnt - r0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule